// File: doc/BRIEF.md
# Edge-Synchronised Reciprocal Frequency Counter

This block measures the rate of an asynchronous pulse train, for example the output of a voltage-to-frequency converter, against the fast reference clock that runs the block. A nominal window of programmable length, counted in reference cycles, sets roughly how long each measurement lasts. The real counting interval is moved onto the measured signal's own rising edges. It opens on the first input edge after the nominal window opens and closes on the first input edge after the nominal window has ended. Because both ends sit on input edges, the interval always holds a whole number N of input periods. The reference cycle count m then resolves the interval to one reference period.

At the end of every measurement the block presents N and m together with a one-cycle valid strobe. Downstream logic computes the frequency as N·F/m, where F is the reference frequency. The block then starts the next nominal window at once, so measurements follow one another without software involvement. A result with too few input periods is marked as low confidence. A missing input is reported as a no-signal result instead of leaving the block hung.

Top module: `recip_freq_counter`

## Requirements
- R1: `sigIn` is sampled by a two-flop synchroniser. A rising edge is recognised in the cycle where the second stage is 1 and a third flop still holds 0, which is two clocks after the level is first sampled. `measValid` goes high in the cycle after the closing edge is recognised.
- R2: A nominal window opens in the first cycle after reset. The first rising edge recognised in or after that cycle opens the counting interval, and `noSignal` is 0 for such a measurement.
- R3: The nominal window closes once `gateLen` cycles have passed since it opened. Only an edge recognised after the first counting cycle in which the window is closed can end the interval. An edge recognised in that same cycle is counted in N but does not end the interval.
- R4: `cycCount` equals the number of edges recognised after the opening edge, up to and including the closing edge. `refCount` equals the number of cycles from the opening edge to the closing edge. Both counters saturate rather than wrap.
- R5: `measValid` is high for exactly one cycle per result. `cycCount`, `refCount`, `lowConf` and `noSignal` are 0 from reset and only change in the cycle `measValid` is high.
- R6: `lowConf` is 1 exactly when the reported `cycCount` is below `minCycles`. This includes no-signal results, which report 0.
- R7: If no edge is recognised within TIMEOUT cycles of the nominal window opening, the result has `noSignal`=1 and zero counts, and is reported in the cycle after the last of those TIMEOUT cycles. An edge in the last of those cycles still opens the interval.
- R8: If no edge is recognised within TIMEOUT cycles after the stop is armed, the result has `noSignal`=1 and zero counts, and is reported in the cycle after the last of those cycles.
- R9: The next nominal window opens in the cycle in which `measValid` is high, with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Asynchronous pulse train being measured |
| gateLen | input | GW | Nominal window length in reference cycles |
| minCycles | input | NW | Minimum input-period count for a confident result |
| measValid | output | 1 | One-cycle strobe marking a new result |
| cycCount | output | NW | Whole input periods N in the counting interval |
| refCount | output | MW | Reference cycles m in the counting interval |
| lowConf | output | 1 | Result has fewer than `minCycles` periods |
| noSignal | output | 1 | Measurement ended by timeout without an edge |

## Verification
Two events can land in the same cycle. The first case is an input edge arriving in the very cycle the nominal window closes: that edge must be counted without ending the interval. The second case is an edge arriving in the last cycle of a timeout, where the edge must win over the timeout. The bench provokes the first case by sweeping input periods against many short gate lengths and phases. It provokes the second case with periods equal to, just below and just above the timeout. Each result is judged against a model that the bench computes from the recorded input waveform. The bench also confirms that both coincidences actually occurred.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  // Measurement phases of the control unit
  typedef enum logic [1:0] {
    PH_SEEK  = 2'd0,  // nominal window open, waiting for the opening edge
    PH_COUNT = 2'd1,  // interval open, nominal window still running
    PH_CLOSE = 2'd2   // nominal window over, waiting for the closing edge
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic openWin;    // restart nominal window and timeout
    logic startMeas;  // clear N and m at the opening edge
    logic countOn;    // interval open: advance m, count edges into N
    logic armStop;    // restart timeout for the closing-edge wait
    logic capOk;      // capture a normal result
    logic capNoSig;   // capture a no-signal result
  } strobes_t;

endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseSeen
);

  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign riseSeen = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rise,
  input  logic     gateClosed,
  input  logic     timedOut,
  output strobes_t st
);

  phase_e phase, nextPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_SEEK;
    else       phase <= nextPhase;
  end

  always_comb begin
    st        = '0;
    nextPhase = phase;
    case (phase)
      PH_SEEK: begin
        if (rise) begin
          st.startMeas = 1'b1;
          nextPhase    = PH_COUNT;
        end else if (timedOut) begin
          st.capNoSig = 1'b1;
          st.openWin  = 1'b1;
        end
      end
      PH_COUNT: begin
        st.countOn = 1'b1;
        if (gateClosed) begin
          st.armStop = 1'b1;
          nextPhase  = PH_CLOSE;
        end
      end
      PH_CLOSE: begin
        st.countOn = 1'b1;
        if (rise) begin
          st.capOk   = 1'b1;
          st.openWin = 1'b1;
          nextPhase  = PH_SEEK;
        end else if (timedOut) begin
          st.capNoSig = 1'b1;
          st.openWin  = 1'b1;
          nextPhase   = PH_SEEK;
        end
      end
      default: nextPhase = PH_SEEK;
    endcase
  end

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_COUNT) |-> $past(rise)); // R2

  AST_STOP_AFTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_CLOSE) |-> $past(gateClosed)); // R3

endmodule

// File: rtl/rfc_datapath.sv
module rfc_datapath
  import rfc_pkg::*;
#(
  parameter int GW      = 16,
  parameter int NW      = 16,
  parameter int MW      = 32,
  parameter int TIMEOUT = 1000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic          rise,
  input  logic [GW-1:0] gateLen,
  input  logic [NW-1:0] minCycles,
  output logic          gateClosed,
  output logic          timedOut,
  output logic          measValid,
  output logic [NW-1:0] cycCount,
  output logic [MW-1:0] refCount,
  output logic          lowConf,
  output logic          noSignal
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT - 1);

  logic [GW-1:0] gateCnt;
  logic [TW-1:0] toCnt;
  logic [NW-1:0] nCnt, nNext;
  logic [MW-1:0] mCnt, mNext;

  assign gateClosed = (gateCnt >= gateLen);
  assign timedOut   = (toCnt == TO_LAST);
  assign nNext      = (rise && !(&nCnt)) ? nCnt + 1'b1 : nCnt;
  assign mNext      = (&mCnt) ? mCnt : mCnt + 1'b1;

  // Nominal window and timeout counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateCnt <= '0;
      toCnt   <= '0;
    end else begin
      if (st.openWin)       gateCnt <= '0;
      else if (!(&gateCnt)) gateCnt <= gateCnt + 1'b1;
      if (st.openWin || st.armStop) toCnt <= '0;
      else if (!timedOut)           toCnt <= toCnt + 1'b1;
    end
  end

  // Interval counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nCnt <= '0;
      mCnt <= '0;
    end else if (st.startMeas) begin
      nCnt <= '0;
      mCnt <= '0;
    end else if (st.countOn) begin
      nCnt <= nNext;
      mCnt <= mNext;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measValid <= 1'b0;
      cycCount  <= '0;
      refCount  <= '0;
      lowConf   <= 1'b0;
      noSignal  <= 1'b0;
    end else begin
      measValid <= st.capOk | st.capNoSig;
      if (st.capOk) begin
        cycCount <= nNext;
        refCount <= mNext;
        lowConf  <= (nNext < minCycles);
        noSignal <= 1'b0;
      end else if (st.capNoSig) begin
        cycCount <= '0;
        refCount <= '0;
        lowConf  <= (minCycles != '0);
        noSignal <= 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    st.countOn |=> mCnt != '0); // R4

  AST_N_WITHIN_M: assert property (@(posedge clk) disable iff (!rstN)
    (measValid && !noSignal) |-> (cycCount != '0 && MW'(cycCount) <= refCount)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    measValid |=> !measValid); // R5

  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    toCnt <= TO_LAST); // R7

  AST_NOSIG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (measValid && noSignal) |-> (cycCount == '0 && refCount == '0)); // R8

endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter
  import rfc_pkg::*;
#(
  parameter int GW          = 16,
  parameter int NW          = 16,
  parameter int MW          = 32,
  parameter int TIMEOUT     = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sigIn,
  input  logic [GW-1:0] gateLen,
  input  logic [NW-1:0] minCycles,
  output logic          measValid,
  output logic [NW-1:0] cycCount,
  output logic [MW-1:0] refCount,
  output logic          lowConf,
  output logic          noSignal
);

  strobes_t st;
  logic rise, gateClosed, timedOut;

  rfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (sigIn),
    .riseSeen (rise)
  );

  rfc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rise       (rise),
    .gateClosed (gateClosed),
    .timedOut   (timedOut),
    .st         (st)
  );

  rfc_datapath #(
    .GW(GW), .NW(NW), .MW(MW), .TIMEOUT(TIMEOUT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .rise       (rise),
    .gateLen    (gateLen),
    .minCycles  (minCycles),
    .gateClosed (gateClosed),
    .timedOut   (timedOut),
    .measValid  (measValid),
    .cycCount   (cycCount),
    .refCount   (refCount),
    .lowConf    (lowConf),
    .noSignal   (noSignal)
  );

endmodule

// File: tb/recip_freq_counter_test.sv
module recip_freq_counter_test;

  localparam int GW = 8;
  localparam int NW = 8;
  localparam int MW = 12;
  localparam int TO = 40;
  localparam int H  = 4096;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sigIn = 1'b0;
  logic [GW-1:0] gateLen = 8'd5;
  logic [NW-1:0] minCycles = '0;
  logic          measValid, lowConf, noSignal;
  logic [NW-1:0] cycCount;
  logic [MW-1:0] refCount;

  recip_freq_counter #(.GW(GW), .NW(NW), .MW(MW), .TIMEOUT(TO), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .gateLen(gateLen), .minCycles(minCycles),
    .measValid(measValid), .cycCount(cycCount), .refCount(refCount),
    .lowConf(lowConf), .noSignal(noSignal)
  );

  always #10 clk = ~clk;  // 50 MHz

  int  cyc = 0;
  int  checks = 0, fails = 0;
  bit  done = 1'b0;
  bit  hist [H];
  // generator settings
  bit  genOn = 1'b0;
  int  per = 4, ph = 0, burstEnd = 0;
  // monitor state
  int  oCur = 0;
  bit  prevValid = 1'b0, holdBad = 1'b0;
  int  heldN = 0, heldM = 0;
  bit  heldL = 1'b0, heldS = 1'b0;
  int  coincCnt = 0, lateCnt = 0, stopToCnt = 0, startToCnt = 0, lowCnt = 0, highCnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    sigIn = genOn && (burstEnd == 0 || cyc < burstEnd) && (((cyc + ph) % per) < per / 2);
    hist[cyc % H] = sigIn;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // edge recognised in cycle k comes from levels driven in cycles k-2 and k-3
  function automatic bit riseAt(int k);
    if (k < 3) return 1'b0;
    return hist[(k - 2) % H] && !hist[(k - 3) % H];
  endfunction

  task automatic model(input int o, output int endC, output int n, output int m,
                       output bit nos, output int phs, output bit coinc, output bit late);
    int start = -1, stop = -1, x;
    n = 0; m = 0; nos = 1'b0; phs = 0; coinc = 1'b0; late = 1'b0;
    for (int k = o; k < o + TO; k++) if (riseAt(k)) begin start = k; break; end
    if (start < 0) begin
      endC = o + TO - 1; nos = 1'b1; phs = 1; return;
    end
    late = (start == o + TO - 1);
    x = (start + 1 > o + int'(gateLen)) ? start + 1 : o + int'(gateLen);
    coinc = riseAt(x);
    for (int k = x + 1; k <= x + TO; k++) if (riseAt(k)) begin stop = k; break; end
    if (stop < 0) begin
      endC = x + TO; nos = 1'b1; phs = 2; return;
    end
    for (int k = start + 1; k <= stop; k++) if (riseAt(k)) n++;
    m = stop - start;
    endC = stop;
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (measValid) begin
        int endC, n, m, phs;
        bit nos, coinc, late, expLow;
        string ntag;
        model(oCur, endC, n, m, nos, phs, coinc, late);
        expLow = (n < int'(minCycles));
        chk(cyc == endC + 1, "R1 R9 result cycle", cyc, endC + 1);
        ntag = (phs == 1) ? "R7 no-signal flag" : (phs == 2) ? "R8 no-signal flag" : "R2 no-signal flag";
        chk(noSignal == nos, ntag, noSignal, nos);
        chk(int'(cycCount) == n, coinc ? "R3 N with edge at gate close" : (nos ? "R8 N zero" : "R4 N"),
            cycCount, n);
        chk(int'(refCount) == m, nos ? "R7 m zero" : "R4 m", refCount, m);
        chk(lowConf == expLow, "R6 low confidence", lowConf, expLow);
        chk(!prevValid, "R5 single-cycle valid", prevValid, 0);
        chk(!holdBad, "R5 outputs held between results", holdBad, 0);
        if (coinc && !nos) coincCnt++;
        if (late) lateCnt++;
        if (phs == 2) stopToCnt++;
        if (phs == 1) startToCnt++;
        if (expLow) lowCnt++; else highCnt++;
        oCur = cyc;
        holdBad = 1'b0;
        heldN = cycCount; heldM = refCount; heldL = lowConf; heldS = noSignal;
      end else if (int'(cycCount) != heldN || int'(refCount) != heldM ||
                   lowConf != heldL || noSignal != heldS) begin
        holdBad = 1'b1;
      end
      prevValid = measValid;
    end
  end

  task automatic waitValids(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      while (!measValid) @(negedge clk);
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    automatic int perList[7] = '{2, 3, 5, 8, 39, 40, 41};
    automatic int gList[7]   = '{1, 2, 3, 4, 5, 7, 12};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    oCur = cyc;
    #1;
    chk(measValid == 1'b0, "R5 reset valid", measValid, 0);
    chk(cycCount == '0 && refCount == '0, "R5 reset counts", cycCount, 0);
    chk(lowConf == 1'b0 && noSignal == 1'b0, "R5 reset flags", {lowConf, noSignal}, 0);
    @(posedge clk); #1;
    genOn = 1'b1;
    foreach (perList[pi]) begin
      foreach (gList[gi]) begin
        per = perList[pi];
        ph = (3 * pi + gi) % per;
        gateLen = GW'(gList[gi]);
        minCycles = NW'((gi % 3) * 2);
        waitValids(2);
      end
    end
    // silent input: start timeouts
    genOn = 1'b0;
    waitValids(2);
    // input vanishes after the interval opened: stop timeout
    genOn = 1'b1; per = 5; ph = 1; gateLen = 8'd40; minCycles = 8'd3;
    burstEnd = cyc + 20;
    waitValids(2);
    burstEnd = 0; per = 3; gateLen = 8'd10;
    waitValids(3);
    chk(coincCnt > 0, "R3 edge at gate close exercised", coincCnt, 1);
    chk(lateCnt > 0, "R7 edge in last timeout cycle exercised", lateCnt, 1);
    chk(startToCnt > 0, "R7 start timeout exercised", startToCnt, 1);
    chk(stopToCnt > 0, "R8 stop timeout exercised", stopToCnt, 1);
    chk(lowCnt > 0 && highCnt > 0, "R6 both confidence outcomes", lowCnt, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule